// File: doc/BRIEF.md
# Supply Switchover and Protected Register Write Guard

This block sits beside the register file of a low-power timekeeping chip. It makes two decisions. The first is whether the chip runs from the main supply or from the backup cell. It takes three digital comparator flags, which arrive asynchronously from the analog section: main supply below the backup level minus hysteresis, main supply below the trip threshold, and backup above main. It also takes a low-power mode bit. From these it produces a filtered battery-mode flag.

The second decision screens register writes coming from the serial front end. Each write burst opens with a start pulse that carries a start address and a declared byte count. After that, one strobe arrives per data byte, and the address advances with each byte. One control register is protected. While the backup cell is above main, that register may only be written as the second byte of a page write that opened one address below it. A blocked byte never reaches the register port and raises a sticky error flag, which software clears.

Top module: `supply_write_guard`

## Requirements
- R1: With `lowPowerMode` low, the battery-mode condition is true only when both `mainBelowBackupHys` and `mainBelowTrip` are high. Either flag alone leaves `battMode` at 0.
- R2: With `lowPowerMode` high, the battery-mode condition is `mainBelowBackupHys` alone, and `mainBelowTrip` is ignored.
- R3: Each comparator flag passes through two synchronizing flops. `battMode` follows the battery-mode condition only after the synchronized condition has held the same value at two consecutive clock edges. An input change that is set up before edge 0 and then held shows on `battMode` after edge 3. A condition pulse lasting one cycle never reaches `battMode`.
- R4: While the synchronized `backupAboveMain` is high, a burst with a declared count of 1 whose address is 0x08 produces no register write.
- R5: While the synchronized `backupAboveMain` is high, a byte aimed at 0x08 is written only if its burst started at 0x07 with a count of 2 or more. If the burst started at any other address, only the 0x08 byte is blocked, and the other bytes of that burst are still written.
- R6: While the synchronized `backupAboveMain` is low, every byte is written, including single-byte and page writes to 0x08.
- R7: A blocked byte gives no `regWrEn` pulse and sets `wrErr` at the next edge. `wrErr` stays high until an edge where `errClr` is high and no byte is being blocked. If a block and a clear fall on the same edge, the block wins.
- R8: At most the declared count of bytes is written per burst. Extra strobes are dropped without an error. A burst cut short, either by a new start or by its strobes stopping, writes only the bytes actually received.
- R9: An accepted byte appears on `regWrEn`/`regWrAddr`/`regWrData` for one cycle, one edge after its strobe. Its address is the start address plus the byte index, modulo 256.
- R10: After reset, `battMode`, `regWrEn` and `wrErr` are 0 and no burst is open, so strobes before the first start are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mainBelowBackupHys | input | 1 | Async flag: main below backup minus hysteresis |
| mainBelowTrip | input | 1 | Async flag: main below trip threshold |
| backupAboveMain | input | 1 | Async flag: backup above main |
| lowPowerMode | input | 1 | Switchover rule select (1 = ignore trip flag) |
| wrStart | input | 1 | Opens a write burst; no byte strobe in the same cycle |
| wrStartAddr | input | 8 | First address of the burst |
| wrCount | input | 4 | Declared byte count of the burst |
| wrByteValid | input | 1 | One data byte present this cycle |
| wrData | input | 8 | Data byte |
| errClr | input | 1 | Clears the sticky write error |
| battMode | output | 1 | Running from the backup cell |
| regWrEn | output | 1 | Register write strobe |
| regWrAddr | output | 8 | Register write address |
| regWrData | output | 8 | Register write data |
| wrErr | output | 1 | Sticky flag: a write was blocked |

## Verification
The bench targets the cases a design is most likely to get wrong:
- A page write starting at 0x06 that runs through 0x08. Keying on "page write" alone would wrongly let the protected byte through.
- A page write at 0x07 with a declared count of 1. This must not unlock the register.
- A block and an error clear on the same edge. A design that gives the clear priority would lose the error.
- Extra strobes beyond the declared count. These would write past the burst if they were not dropped.
- Address wrap from 0xFF to 0x00.
- Switchover rules: the bench toggles the trip flag under both low-power settings, drives a one-cycle comparator pulse that must be filtered out, and checks the exact edge at which `battMode` moves. An off-by-one in the filter or in the synchronizer shows up there.

// File: rtl/swg_pkg.sv
package swg_pkg;
  typedef struct packed {
    logic burstLoad;
    logic byteAccept;
    logic byteReject;
  } guardStrobes_t;
endpackage

// File: rtl/swg_ctrl.sv
module swg_ctrl
  import swg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 'h08,
  parameter logic [ADDR_W-1:0] PAGE_ADDR = 'h07
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mainBelowBackupHys,
  input  logic              mainBelowTrip,
  input  logic              backupAboveMain,
  input  logic              lowPowerMode,
  input  logic              wrStart,
  input  logic              wrByteValid,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [ADDR_W-1:0] burstBase,
  input  logic [CNT_W-1:0]  burstLen,
  input  logic [CNT_W-1:0]  bytesLeft,
  output guardStrobes_t     strobes,
  output logic              battMode,
  output logic              backupHigh
);
  localparam int FLAG_N = 3;

  logic [FLAG_N-1:0] rawFlags;
  logic [SYNC_STAGES-1:0][FLAG_N-1:0] syncPipe;
  logic [FLAG_N-1:0] syncFlags;
  logic belowHysS, belowTripS, battCond, condQ;
  logic inBurst, hitProt, pageOk, permit, byteIn;

  assign rawFlags = {backupAboveMain, mainBelowTrip, mainBelowBackupHys};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[SYNC_STAGES-2:0], rawFlags};
  end

  assign syncFlags  = syncPipe[SYNC_STAGES-1];
  assign belowHysS  = syncFlags[0];
  assign belowTripS = syncFlags[1];
  assign backupHigh = syncFlags[2];

  // low-power mode drops the trip threshold from the switchover rule
  assign battCond = lowPowerMode ? belowHysS : (belowHysS & belowTripS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      condQ    <= 1'b0;
      battMode <= 1'b0;
    end else begin
      condQ <= battCond;
      if (battCond == condQ) battMode <= battCond;
    end
  end

  assign inBurst = bytesLeft != '0;
  assign hitProt = curAddr == PROT_ADDR;
  assign pageOk  = (burstBase == PAGE_ADDR) && (burstLen >= CNT_W'(2));
  assign permit  = !backupHigh || !hitProt || pageOk;
  assign byteIn  = !wrStart && wrByteValid && inBurst;

  always_comb begin
    strobes.burstLoad  = wrStart;
    strobes.byteAccept = byteIn && permit;
    strobes.byteReject = byteIn && !permit;
  end

  AST_BATT_FILTER: assert property (@(posedge clk) disable iff (!rstN)
    (battMode != $past(battMode)) |-> ($past(battCond) == $past(condQ))) else $error("battMode moved on unsettled condition"); // R3
  AST_SINGLE_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (backupHigh && byteIn && hitProt && burstLen == CNT_W'(1)) |-> !strobes.byteAccept) else $error("single write to protected register accepted"); // R4
  AST_START_NO_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    wrStart |-> !(strobes.byteAccept || strobes.byteReject)) else $error("byte handled in start cycle"); // R8
endmodule

// File: rtl/swg_datapath.sv
module swg_datapath
  import swg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  guardStrobes_t     strobes,
  input  logic [ADDR_W-1:0] wrStartAddr,
  input  logic [CNT_W-1:0]  wrCount,
  input  logic [DATA_W-1:0] wrData,
  input  logic              errClr,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] burstBase,
  output logic [CNT_W-1:0]  burstLen,
  output logic [CNT_W-1:0]  bytesLeft,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              wrErr
);
  logic stepByte;
  assign stepByte = strobes.byteAccept || strobes.byteReject;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr   <= '0;
      burstBase <= '0;
      burstLen  <= '0;
      bytesLeft <= '0;
      regWrEn   <= 1'b0;
      regWrAddr <= '0;
      regWrData <= '0;
      wrErr     <= 1'b0;
    end else begin
      regWrEn <= strobes.byteAccept;
      if (strobes.byteAccept) begin
        regWrAddr <= curAddr;
        regWrData <= wrData;
      end
      if (strobes.burstLoad) begin
        curAddr   <= wrStartAddr;
        burstBase <= wrStartAddr;
        burstLen  <= wrCount;
        bytesLeft <= wrCount;
      end else if (stepByte) begin
        curAddr   <= curAddr + ADDR_W'(1);
        bytesLeft <= bytesLeft - CNT_W'(1);
      end
      if (strobes.byteReject) wrErr <= 1'b1;
      else if (errClr)        wrErr <= 1'b0;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (wrErr && !errClr) |=> wrErr) else $error("error flag lost"); // R7
  AST_REJECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.byteReject |=> (!regWrEn && wrErr)) else $error("blocked byte written"); // R7
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> ($past(bytesLeft) != '0)) else $error("write beyond declared count"); // R8
endmodule

// File: rtl/supply_write_guard.sv
module supply_write_guard
  import swg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 'h08,
  parameter logic [ADDR_W-1:0] PAGE_ADDR = 'h07
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mainBelowBackupHys,
  input  logic              mainBelowTrip,
  input  logic              backupAboveMain,
  input  logic              lowPowerMode,
  input  logic              wrStart,
  input  logic [ADDR_W-1:0] wrStartAddr,
  input  logic [CNT_W-1:0]  wrCount,
  input  logic              wrByteValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              errClr,
  output logic              battMode,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              wrErr
);
  guardStrobes_t strobes;
  logic [ADDR_W-1:0] curAddr, burstBase;
  logic [CNT_W-1:0] burstLen, bytesLeft;
  logic backupHigh;

  swg_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES),
    .PROT_ADDR(PROT_ADDR), .PAGE_ADDR(PAGE_ADDR)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .mainBelowBackupHys(mainBelowBackupHys), .mainBelowTrip(mainBelowTrip),
    .backupAboveMain(backupAboveMain), .lowPowerMode(lowPowerMode),
    .wrStart(wrStart), .wrByteValid(wrByteValid),
    .curAddr(curAddr), .burstBase(burstBase), .burstLen(burstLen), .bytesLeft(bytesLeft),
    .strobes(strobes), .battMode(battMode), .backupHigh(backupHigh)
  );

  swg_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrStartAddr(wrStartAddr), .wrCount(wrCount), .wrData(wrData), .errClr(errClr),
    .curAddr(curAddr), .burstBase(burstBase), .burstLen(burstLen), .bytesLeft(bytesLeft),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData), .wrErr(wrErr)
  );

  AST_PROT_RULE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrAddr == PROT_ADDR && $past(backupHigh))
      |-> ($past(burstBase) == PAGE_ADDR && $past(burstLen) >= CNT_W'(2))) else $error("protected write outside page rule"); // R5
  AST_WRITE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> $past(wrByteValid)) else $error("write without byte strobe"); // R9
endmodule

// File: tb/tb_supply_write_guard.sv
module tb_supply_write_guard;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mainBelowBackupHys = 0, mainBelowTrip = 0, backupAboveMain = 0, lowPowerMode = 0;
  logic wrStart = 0, wrByteValid = 0, errClr = 0;
  logic [7:0] wrStartAddr = '0, wrData = '0;
  logic [3:0] wrCount = '0;
  logic battMode, regWrEn, wrErr;
  logic [7:0] regWrAddr, regWrData;

  int checks = 0, errors = 0, cycles = 0;
  string curReq = "R10";

  always #2 clk = ~clk;

  supply_write_guard dut (
    .clk(clk), .rstN(rstN),
    .mainBelowBackupHys(mainBelowBackupHys), .mainBelowTrip(mainBelowTrip),
    .backupAboveMain(backupAboveMain), .lowPowerMode(lowPowerMode),
    .wrStart(wrStart), .wrStartAddr(wrStartAddr), .wrCount(wrCount),
    .wrByteValid(wrByteValid), .wrData(wrData), .errClr(errClr),
    .battMode(battMode), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .wrErr(wrErr)
  );

  // behavioural reference model
  bit [2:0] flagHist[$];
  bit condHist[$];
  bit mBatt, mEn, mErr;
  int mAddr, mData, mNext, mLeft, mBase, mLen;

  always @(posedge clk) begin
    if (!rstN) begin
      flagHist = '{3'b000, 3'b000};
      condHist = '{1'b0};
      mBatt = 0; mEn = 0; mErr = 0; mLeft = 0; mNext = 0; mBase = 0; mLen = 0;
      mAddr = 0; mData = 0;
    end else begin
      bit [2:0] seen;
      bit cond, bh, ok;
      seen = flagHist[1];
      cond = lowPowerMode ? seen[0] : (seen[0] && seen[1]);
      bh = seen[2];
      if (cond == condHist[0]) mBatt = cond;
      condHist.push_front(cond); void'(condHist.pop_back());
      flagHist.push_front({backupAboveMain, mainBelowTrip, mainBelowBackupHys});
      void'(flagHist.pop_back());
      mEn = 0;
      if (errClr) mErr = 0;
      if (wrStart) begin
        mNext = wrStartAddr; mBase = wrStartAddr; mLen = wrCount; mLeft = wrCount;
      end else if (wrByteValid && mLeft > 0) begin
        ok = !(bh && mNext == 8 && !(mBase == 7 && mLen >= 2));
        if (ok) begin mEn = 1; mAddr = mNext; mData = wrData; end
        else mErr = 1;
        mNext = (mNext + 1) % 256; mLeft--;
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      check(curReq, "battMode", battMode, mBatt);
      check(curReq, "regWrEn", regWrEn, mEn);
      check(curReq, "wrErr", wrErr, mErr);
      if (mEn) begin
        check(curReq, "regWrAddr", regWrAddr, mAddr);
        check(curReq, "regWrData", regWrData, mData);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic burst(input logic [7:0] a, input int cnt, input int nBytes, input logic clrAtByte);
    @(negedge clk);
    wrStart = 1; wrStartAddr = a; wrCount = 4'(cnt);
    @(negedge clk);
    wrStart = 0;
    for (int i = 0; i < nBytes; i++) begin
      wrByteValid = 1; wrData = 8'(8'h40 + 8'(i) + a); errClr = clrAtByte;
      @(negedge clk);
    end
    wrByteValid = 0; errClr = 0;
  endtask

  task automatic clearErr();
    @(negedge clk); errClr = 1;
    @(negedge clk); errClr = 0;
  endtask

  initial begin
    idle(2);
    check("R10", "battMode reset", battMode, 0);
    check("R10", "regWrEn reset", regWrEn, 0);
    check("R10", "wrErr reset", wrErr, 0);
    rstN = 1;
    curReq = "R10";
    wrByteValid = 1; wrData = 8'h11; @(negedge clk); wrByteValid = 0;
    check("R10", "stray byte before start", regWrEn, 0);
    idle(2);

    curReq = "R6";
    burst(8'h08, 1, 1, 0); idle(2);
    burst(8'h06, 3, 3, 0); idle(2);
    check("R6", "no error with main higher", wrErr, 0);

    backupAboveMain = 1; idle(4);
    curReq = "R4";
    burst(8'h08, 1, 1, 0); idle(1);
    check("R4", "single write blocked sets error", wrErr, 1);
    clearErr();
    check("R7", "error cleared", wrErr, 0);
    curReq = "R7";
    burst(8'h08, 1, 1, 1); idle(1);
    check("R7", "block wins over clear", wrErr, 1);
    clearErr();

    curReq = "R5";
    burst(8'h07, 2, 2, 0); idle(1);
    check("R5", "page from 07 allowed", wrErr, 0);
    burst(8'h06, 3, 3, 0); idle(1);
    check("R5", "page from 06 blocked at 08", wrErr, 1);
    clearErr();
    burst(8'h07, 1, 2, 0); idle(1);
    check("R5", "count 1 at 07 does not unlock", wrErr, 0);
    burst(8'h08, 2, 2, 0); idle(1);
    check("R5", "page from 08 blocked", wrErr, 1);
    clearErr();

    curReq = "R8";
    burst(8'h07, 4, 1, 0);
    burst(8'h20, 2, 3, 0);
    burst(8'h30, 0, 2, 0); idle(1);
    check("R8", "extra strobes give no error", wrErr, 0);

    curReq = "R9";
    burst(8'hFE, 3, 3, 0); idle(2);

    backupAboveMain = 0;
    curReq = "R1";
    mainBelowBackupHys = 1; idle(6);
    check("R1", "hysteresis alone", battMode, 0);
    mainBelowBackupHys = 0; mainBelowTrip = 1; idle(6);
    check("R1", "trip alone", battMode, 0);
    curReq = "R3";
    mainBelowBackupHys = 1;
    idle(3);
    check("R3", "not yet after three edges", battMode, 0);
    idle(1);
    check("R3", "set after fourth edge", battMode, 1);
    mainBelowBackupHys = 0; idle(6);
    check("R3", "back to main", battMode, 0);
    mainBelowBackupHys = 1; idle(1); mainBelowBackupHys = 0; idle(6);
    check("R3", "one-cycle pulse filtered", battMode, 0);
    curReq = "R2";
    lowPowerMode = 1; mainBelowTrip = 0; mainBelowBackupHys = 1; idle(6);
    check("R2", "low power ignores trip", battMode, 1);
    lowPowerMode = 0; idle(4);
    check("R1", "normal mode needs trip", battMode, 0);
    idle(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule